// File: doc/BRIEF.md
# VFD Command Decoder and Display Loader

This block sits behind a serial byte receiver in a vacuum fluorescent display controller. Each received byte arrives with a one-cycle valid strobe, together with the level of an active-low frame select. The block reads the top three bits of each byte to find its command class. It keeps the display configuration in registers: the segment width mode, the grid count, display enable, duty, the first grid pin and the eight port output bits.

A display-data setup command switches the current frame into loading mode. From then on, every byte in that frame becomes a write into a per-grid display memory. Each grid takes three bytes in wide segment mode and two bytes in narrow mode. Grid slots sit four addresses apart, starting at 0x09. Once the configured number of grids has been filled, further bytes are dropped. Raising the frame select ends the frame. The next frame then begins again with command decoding.

The loader is a three-state machine. `ST_CMD` decodes bytes as commands. It moves to `ST_DATA` on a setup command. `ST_DATA` issues memory writes, and it moves to `ST_FULL` after the last byte of the last grid. `ST_FULL` drops all bytes. A high frame select returns any state to `ST_CMD`.

Top module: `vfd_cmd_loader`

## Requirements
- R1: After reset: display off, duty code 00, grid count code 00 (7 grids), narrow segment mode, grid start code 0000, all eight port bits 0, no memory write.
- R2: A command byte with bits 7..5 = 111 sets seg_wide to bit 2 and grid_cnt to bits 1..0, visible the cycle after the byte. Grid count codes map as 00 = 7, 01 = 8, 10 = 9, 11 = 10 grids.
- R3: A command byte with bits 7..5 = 110 sets disp_on to bit 2 and duty to bits 1..0 (00 = 5/16, 01 = 6/16, 10 = 14/16, 11 = 15/16).
- R4: A command byte with bits 7..5 = 101 sets grid_start to bits 3..0 when that code is 0..10. A larger code leaves grid_start unchanged.
- R5: A command byte with bits 7..5 = 100 writes bits 3..0 into port_data[3:0] when bit 4 = 0, or into port_data[7:4] when bit 4 = 1. The other nibble is kept.
- R6: A command byte with bit 7 = 0 changes no output.
- R7: In wide mode, the n-th data byte after the setup command in the same frame is written at address 0x09 + 4*(n div 3) + (n mod 3), with n counted from 0.
- R8: In narrow mode, the n-th data byte is written at address 0x09 + 4*(n div 2) + (n mod 2) + 1.
- R9: Data bytes beyond the configured grid count cause no write.
- R10: Bytes strobed while cs_n is high are ignored. After cs_n has been high, the first byte of the new frame is decoded as a command.
- R11: Each accepted data byte gives mem_we high for exactly one cycle, the cycle after the byte, with mem_data equal to the byte. Several non-data commands may share one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Frame select, active low; high ends the frame |
| byte_valid | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte |
| seg_wide | output | 1 | 1 = 17 or more segments (3 bytes per grid) |
| grid_cnt | output | 2 | Grid count code |
| disp_on | output | 1 | Display enable |
| duty | output | 2 | Dimming duty code |
| grid_start | output | 4 | First grid pin code, 0..10 |
| port_data | output | 8 | Port output bits |
| mem_we | output | 1 | Display memory write strobe |
| mem_addr | output | 6 | Display memory address |
| mem_data | output | 8 | Display memory write data |

## Verification
The assertions assume that byte_valid is a single-cycle strobe and that the segment mode does not change while a frame is in loading mode. Both hold because the setup command is the only thing that sets the mode, and later bytes in that frame are data. The bench gaps every byte by at least one idle cycle and raises cs_n for a full cycle between frames. It biases random frame openers towards the setup command, so that wide, narrow and overflow loads all occur.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_DATA = 2'd1,
        ST_FULL = 2'd2
    } ld_state_t;

    localparam logic [2:0] OP_SETUP = 3'b111;
    localparam logic [2:0] OP_STATE = 3'b110;
    localparam logic [2:0] OP_GSEL  = 3'b101;
    localparam logic [2:0] OP_PORT  = 3'b100;
endpackage

// File: rtl/vfd_cfg_regs.sv
module vfd_cfg_regs
    import vfd_pkg::*;
#(
    parameter int GSTART_MAX = 10,
    parameter int PORT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic [7:0]        cmd_byte,
    output logic              seg_wide,
    output logic [1:0]        grid_cnt,
    output logic              disp_on,
    output logic [1:0]        duty,
    output logic [3:0]        grid_start,
    output logic [PORT_W-1:0] port_data
);
    localparam int NIB = PORT_W / 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_wide   <= 1'b0;
            grid_cnt   <= 2'b00;
            disp_on    <= 1'b0;
            duty       <= 2'b00;
            grid_start <= 4'd0;
            port_data  <= '0;
        end else if (cmd_stb) begin
            unique case (cmd_byte[7:5])
                OP_SETUP: begin
                    seg_wide <= cmd_byte[2];
                    grid_cnt <= cmd_byte[1:0];
                end
                OP_STATE: begin
                    disp_on <= cmd_byte[2];
                    duty    <= cmd_byte[1:0];
                end
                OP_GSEL: begin
                    if (int'(cmd_byte[3:0]) <= GSTART_MAX)
                        grid_start <= cmd_byte[3:0];
                end
                OP_PORT: begin
                    if (cmd_byte[4])
                        port_data[PORT_W-1:NIB] <= cmd_byte[NIB-1:0];
                    else
                        port_data[NIB-1:0] <= cmd_byte[NIB-1:0];
                end
                default: ;
            endcase
        end
    end

    AST_GSTART_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(grid_start) <= GSTART_MAX); // R4

    AST_IDLE_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb |=> $stable(port_data) && $stable(duty) && $stable(disp_on)); // R6
endmodule

// File: rtl/vfd_mem_loader.sv
module vfd_mem_loader
    import vfd_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int BASE_ADDR = 9,
    parameter int STRIDE    = 4,
    parameter int MAX_GRIDS = 10,
    parameter int MIN_GRIDS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              seg_wide,
    input  logic [1:0]        grid_cnt,
    output logic              cmd_stb,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data
);
    localparam int GIDX_W   = $clog2(MAX_GRIDS);
    localparam int ADDR_TOP = BASE_ADDR + STRIDE * (MAX_GRIDS - 1) + 2;

    ld_state_t          state, state_nx;
    logic [GIDX_W-1:0]  gidx, gidx_nx;
    logic [1:0]         bidx, bidx_nx;
    logic               take;
    logic               last_byte;
    logic               last_grid;
    logic [ADDR_W-1:0]  addr_calc;
    logic [GIDX_W-1:0]  gidx_last;

    assign take      = byte_valid && !cs_n;
    assign cmd_stb   = take && (state == ST_CMD);
    assign gidx_last = GIDX_W'(MIN_GRIDS - 1) + GIDX_W'(grid_cnt);
    assign last_byte = seg_wide ? (bidx == 2'd2) : (bidx == 2'd1);
    assign last_grid = (gidx == gidx_last);
    assign addr_calc = ADDR_W'(BASE_ADDR) + ADDR_W'(gidx) * ADDR_W'(STRIDE)
                     + ADDR_W'(bidx) + (seg_wide ? ADDR_W'(0) : ADDR_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CMD;
            gidx  <= '0;
            bidx  <= '0;
        end else begin
            state <= state_nx;
            gidx  <= gidx_nx;
            bidx  <= bidx_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        gidx_nx  = gidx;
        bidx_nx  = bidx;
        if (cs_n) begin
            state_nx = ST_CMD;
            gidx_nx  = '0;
            bidx_nx  = '0;
        end else if (take) begin
            unique case (state)
                ST_CMD: begin
                    if (byte_data[7:5] == OP_SETUP) begin
                        state_nx = ST_DATA;
                        gidx_nx  = '0;
                        bidx_nx  = '0;
                    end
                end
                ST_DATA: begin
                    if (last_byte) begin
                        bidx_nx = '0;
                        if (last_grid) state_nx = ST_FULL;
                        else           gidx_nx  = gidx + 1'b1;
                    end else begin
                        bidx_nx = bidx + 1'b1;
                    end
                end
                ST_FULL: ;
                default: state_nx = ST_CMD;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else begin
            mem_we <= take && (state == ST_DATA);
            if (take && (state == ST_DATA)) begin
                mem_addr <= addr_calc;
                mem_data <= byte_data;
            end
        end
    end

    AST_WE_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(byte_valid && !cs_n)); // R10

    AST_ADDR_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(mem_addr) >= BASE_ADDR) && (int'(mem_addr) <= ADDR_TOP)); // R7

    AST_CS_HIGH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !mem_we); // R10

    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !byte_valid |=> !mem_we); // R11
endmodule

// File: rtl/vfd_cmd_loader.sv
module vfd_cmd_loader
    import vfd_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int BASE_ADDR = 9,
    parameter int STRIDE    = 4,
    parameter int MAX_GRIDS = 10,
    parameter int MIN_GRIDS = 7,
    parameter int PORT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              seg_wide,
    output logic [1:0]        grid_cnt,
    output logic              disp_on,
    output logic [1:0]        duty,
    output logic [3:0]        grid_start,
    output logic [PORT_W-1:0] port_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data
);
    localparam int GSTART_MAX = 10;

    logic cmd_stb;

    vfd_mem_loader #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE),
        .MAX_GRIDS(MAX_GRIDS), .MIN_GRIDS(MIN_GRIDS)
    ) u_loader (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .seg_wide(seg_wide), .grid_cnt(grid_cnt),
        .cmd_stb(cmd_stb),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    vfd_cfg_regs #(
        .GSTART_MAX(GSTART_MAX), .PORT_W(PORT_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cmd_stb(cmd_stb), .cmd_byte(byte_data),
        .seg_wide(seg_wide), .grid_cnt(grid_cnt),
        .disp_on(disp_on), .duty(duty),
        .grid_start(grid_start), .port_data(port_data)
    );

    AST_NARROW_SKIPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !seg_wide |-> mem_addr[1:0] != 2'b01); // R8

    AST_SLOT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[1:0] != 2'b00); // R7
endmodule

// File: tb/test_vfd_cmd_loader.sv
`timescale 1ns/1ps
module test_vfd_cmd_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       seg_wide, disp_on, mem_we;
    logic [1:0] grid_cnt, duty;
    logic [3:0] grid_start;
    logic [7:0] port_data, mem_data;
    logic [5:0] mem_addr;

    int checks = 0;
    int errors = 0;

    // model state
    logic       m_wide = 0, m_on = 0;
    logic [1:0] m_gcnt = 0, m_duty = 0;
    logic [3:0] m_gs = 0;
    logic [7:0] m_port = 0;
    int         m_mode = 0;  // 0 cmd, 1 data
    int         m_n = 0;     // data byte index in frame

    always #2 clk = ~clk;

    vfd_cmd_loader i_vfd_cmd_loader (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .seg_wide(seg_wide), .grid_cnt(grid_cnt), .disp_on(disp_on),
        .duty(duty), .grid_start(grid_start), .port_data(port_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int data_addr(input int n, input logic wide);
        if (wide) return 9 + 4 * (n / 3) + (n % 3);
        return 9 + 4 * (n / 2) + (n % 2) + 1;
    endfunction

    function automatic int data_limit(input logic wide, input logic [1:0] gc);
        return (wide ? 3 : 2) * (7 + int'(gc));
    endfunction

    task automatic chk_cfg(input string tag);
        chk(seg_wide, m_wide, tag);
        chk(grid_cnt, m_gcnt, tag);
        chk(disp_on, m_on, tag);
        chk(duty, m_duty, tag);
        chk(grid_start, m_gs, tag);
        chk(port_data, m_port, tag);
    endtask

    // drive one byte at a negedge, check one cycle later
    task automatic send(input logic [7:0] b, input logic cs_hi);
        logic  exp_we;
        int    exp_addr;
        string tag;
        exp_we = 0; exp_addr = 0;
        cs_n = cs_hi;
        byte_valid = 1'b1;
        byte_data = b;
        if (cs_hi) begin
            tag = "R10"; m_mode = 0; m_n = 0;
        end else if (m_mode == 1) begin
            if (m_n < data_limit(m_wide, m_gcnt)) begin
                exp_we = 1;
                exp_addr = data_addr(m_n, m_wide);
                tag = m_wide ? "R7" : "R8";
            end else tag = "R9";
            m_n++;
        end else begin
            case (b[7:5])
                3'b111: begin tag = "R2"; m_wide = b[2]; m_gcnt = b[1:0]; m_mode = 1; m_n = 0; end
                3'b110: begin tag = "R3"; m_on = b[2]; m_duty = b[1:0]; end
                3'b101: begin tag = "R4"; if (b[3:0] <= 4'd10) m_gs = b[3:0]; end
                3'b100: begin tag = "R5"; if (b[4]) m_port[7:4] = b[3:0]; else m_port[3:0] = b[3:0]; end
                default: tag = "R6";
            endcase
        end
        @(negedge clk);
        byte_valid = 1'b0;
        chk(mem_we, exp_we, tag);
        if (exp_we) begin
            chk(mem_addr, exp_addr, tag);
            chk(mem_data, b, "R11");
        end
        chk_cfg(tag);
        @(negedge clk);
        chk(mem_we, 0, "R11");
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        m_mode = 0; m_n = 0;
        @(negedge clk);
        cs_n = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_we, 0, "R1");
        chk_cfg("R1");
        cs_n = 1'b0;

        // directed: many commands in one frame
        send(8'hC7, 0);
        send(8'hAB, 0);   // code 11: ignored R4
        send(8'hA5, 0);
        send(8'hAF, 0);   // ignored R4
        send(8'h9A, 0);
        send(8'h95, 0);
        send(8'h3F, 0);   // R6
        send(8'h7E, 0);   // R6
        end_frame();

        // wide mode, 8 grids, plus overflow
        send(8'hE5, 0);
        for (int i = 0; i < 26; i++) send(8'(i + 8'h40), 0);
        end_frame();

        // narrow mode, 10 grids, plus overflow
        send(8'hE3, 0);
        for (int i = 0; i < 21; i++) send(8'(i + 8'h80), 0);
        end_frame();

        // bytes while cs high are ignored; then new frame decodes command
        send(8'hE0, 0);
        send(8'h11, 0);
        send(8'hC4, 1);
        send(8'h22, 1);
        cs_n = 1'b0;
        send(8'hC5, 0);
        send(8'hE4, 0);
        send(8'h33, 0);
        end_frame();

        // random frames
        for (int f = 0; f < 300; f++) begin
            logic [7:0] first;
            int len;
            first = 8'($urandom);
            if ($urandom_range(3) == 0) first[7:5] = 3'b111;
            len = $urandom_range(1, 34);
            send(first, 0);
            for (int k = 1; k < len; k++) send(8'($urandom), 0);
            end_frame();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule